// File: doc/BRIEF.md
# Two-Winding Stepper Microstep Sequencer

This block turns a step strobe and a direction bit into the drive pattern for the two windings of a bipolar stepper motor. For each winding it produces one direction bit and one 4-bit current-level code. The codes feed an external current DAC through active-low level inputs. Three stepping modes are available: full step with one winding energised at a time, half step, and microstep, which uses all sixteen amplitude codes.

Internally the block holds a single electrical angle. That angle counts in the finest microstep unit, 64 per electrical cycle at the default parameters. Each strobe moves the angle by one grid step of the active mode. A change of mode snaps the angle to the nearest point on the new grid. Winding 2 uses the same amplitude profile as winding 1, shifted back by a quarter cycle. The outputs are decoded directly from registered state, so they settle in the cycle after the strobe or mode change is sampled.

Top module: `microstep_seq`

## Requirements
- R1: While reset is held, and right after it is released, the position index reads 0 and the mode is full step. Winding 1 then has direction 1 and level code 0000. Winding 2 has direction 0 and level code 1111.
- R2: A level code is active-low. Codes 0000 to 1110 select 100, 98.4, 95.2, 92.1, 88.9, 82.5, 77.8, 71.4, 63.5, 55.6, 47.6, 38.1, 28.6, 19.1 and 9.5 percent of maximum current, and 1111 selects no current.
- R3: Mode input 00 is full step, with 4 positions per cycle spaced 16 angle units apart. In this mode exactly one winding has code 1111, and the other has code 0000.
- R4: Mode input 01 is half step, with 8 positions spaced 8 units apart. Winding 1 codes by position are 0000, 0111, 1111, 0111, 0000, 0111, 1111, 0111.
- R5: Mode input 10 is microstep, with 64 positions. A winding's code equals its distance q (0..16) from the nearest of its angles 0 and 32, except that q = 16 gives 1111.
- R6: At angle a, winding 2's direction and code equal winding 1's at angle a-16 (mod 64), which is a quarter-cycle lag.
- R7: A winding's direction bit is 1 exactly when its own angle w satisfies w < 16 or w > 48. The bit therefore changes only on a step where that winding's old or new code is 1111.
- R8: A strobe moves the angle forward by one grid step when the reverse input is 0 and backward when it is 1, wrapping modulo 64. The position index output is the angle divided by the grid step of the mode.
- R9: Without a strobe, and with the mode unchanged, the position and all outputs hold, whatever the reverse input does.
- R10: When the mode changes, the angle is rounded to the nearest grid point of the new mode, with ties going upward and wrapping at 64. A strobe in the same cycle then steps from the rounded angle. Mode input 11 behaves as microstep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle step strobe |
| rev_i | input | 1 | 1 = retreat on strobe, 0 = advance |
| mode_i | input | 2 | 00 full, 01 half, 10 or 11 microstep |
| ph1_o | output | 1 | Winding 1 direction (1: current A to B) |
| ph2_o | output | 1 | Winding 2 direction (1: current A to B) |
| lvl1_o | output | LVL_W | Winding 1 active-low level code |
| lvl2_o | output | LVL_W | Winding 2 active-low level code |
| pos_o | output | LVL_W+2 | Position index in units of the active mode |

## Verification
The bench builds the block with the default LVL_W of 4, which gives a 64-unit electrical cycle and 16 amplitude codes. At this size one sweep of 64 strobes in microstep mode covers every code, both direction flips of each winding and the wrap of the angle. It also reaches the remap corner cases: ties rounding upward, a snap that wraps past 63 to 0, and a mode change in the same cycle as a strobe.

// File: rtl/usq_pkg.sv
package usq_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_HALF  = 2'b01,
        MODE_MICRO = 2'b10,
        MODE_RSVD  = 2'b11
    } step_mode_e;

    // log2 of the grid step, in finest angle units, for a mode
    function automatic int unsigned grid_log2(step_mode_e m, int unsigned ang_w);
        case (m)
            MODE_FULL: return ang_w - 2;
            MODE_HALF: return ang_w - 3;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/usq_position.sv
module usq_position
    import usq_pkg::*;
#(
    parameter int unsigned ANG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             rev_i,
    input  logic [1:0]       mode_i,
    output logic [ANG_W-1:0] angle_o,
    output step_mode_e       mode_o
);

    typedef struct packed {
        logic [ANG_W-1:0] angle;
        step_mode_e       mode;
    } pos_state_t;

    pos_state_t       st_d, st_q;
    step_mode_e       mode_req;
    logic [ANG_W-1:0] grid;
    logic [ANG_W-1:0] half_grid;
    logic [ANG_W-1:0] grid_mask;
    logic [ANG_W-1:0] snapped;

    always_comb begin
        mode_req  = (mode_i == MODE_RSVD) ? MODE_MICRO : step_mode_e'(mode_i);
        grid      = ANG_W'(1) << grid_log2(mode_req, ANG_W);
        half_grid = grid >> 1;
        grid_mask = ~(grid - ANG_W'(1));
        // snapping leaves an on-grid angle untouched, so it is applied every cycle
        snapped   = (st_q.angle + half_grid) & grid_mask;

        st_d.mode  = mode_req;
        st_d.angle = snapped;
        if (step_i) begin
            st_d.angle = rev_i ? (snapped - grid) : (snapped + grid);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{angle: '0, mode: MODE_FULL};
        end else begin
            st_q <= st_d;
        end
    end

    assign angle_o = st_q.angle;
    assign mode_o  = st_q.mode;

endmodule

// File: rtl/usq_winding.sv
module usq_winding
    import usq_pkg::*;
#(
    parameter int unsigned LVL_W  = 4,
    parameter int unsigned OFFSET = 0
) (
    input  logic [LVL_W+1:0] angle_i,
    input  step_mode_e       mode_i,
    output logic             ph_o,
    output logic [LVL_W-1:0] lvl_o
);

    localparam int unsigned ANG_W    = LVL_W + 2;
    localparam int unsigned QTR      = 2 ** LVL_W;
    localparam int unsigned HALF_LVL = QTR / 2 - 1;

    logic [ANG_W-1:0] w_d;
    logic [LVL_W:0]   r_d;
    logic [LVL_W:0]   q_d;
    logic             off_d;

    always_comb begin
        w_d   = angle_i - ANG_W'(OFFSET);
        r_d   = w_d[LVL_W:0];
        // distance from the nearest positive or negative axis of this winding
        q_d   = (r_d <= (LVL_W+1)'(QTR)) ? r_d : ((LVL_W+1)'(0) - r_d);
        off_d = (q_d == (LVL_W+1)'(QTR));
        ph_o  = (w_d < ANG_W'(QTR)) || (w_d > ANG_W'(3 * QTR));

        if (off_d) begin
            lvl_o = '1;
        end else begin
            case (mode_i)
                MODE_FULL: lvl_o = '0;
                MODE_HALF: lvl_o = (q_d == '0) ? '0 : LVL_W'(HALF_LVL);
                default:   lvl_o = q_d[LVL_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/microstep_seq.sv
module microstep_seq
    import usq_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             rev_i,
    input  logic [1:0]       mode_i,
    output logic             ph1_o,
    output logic             ph2_o,
    output logic [LVL_W-1:0] lvl1_o,
    output logic [LVL_W-1:0] lvl2_o,
    output logic [LVL_W+1:0] pos_o
);

    localparam int unsigned ANG_W = LVL_W + 2;
    localparam int unsigned QTR   = 2 ** LVL_W;
    localparam int unsigned N_WND = 2;

    logic [ANG_W-1:0] angle_q;
    step_mode_e       mode_q;
    logic             ph_w  [N_WND];
    logic [LVL_W-1:0] lvl_w [N_WND];

    usq_position #(.ANG_W(ANG_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .rev_i   (rev_i),
        .mode_i  (mode_i),
        .angle_o (angle_q),
        .mode_o  (mode_q)
    );

    for (genvar g = 0; g < N_WND; g++) begin : g_wnd
        usq_winding #(.LVL_W(LVL_W), .OFFSET(g * QTR)) u_wnd (
            .angle_i (angle_q),
            .mode_i  (mode_q),
            .ph_o    (ph_w[g]),
            .lvl_o   (lvl_w[g])
        );
    end

    assign ph1_o  = ph_w[0];
    assign ph2_o  = ph_w[1];
    assign lvl1_o = lvl_w[0];
    assign lvl2_o = lvl_w[1];
    assign pos_o  = angle_q >> grid_log2(mode_q, ANG_W);

endmodule

// File: rtl/microstep_seq_chk.sv
module microstep_seq_chk
    import usq_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_i,
    input logic             rev_i,
    input logic [1:0]       mode_i,
    input logic             ph1_o,
    input logic             ph2_o,
    input logic [LVL_W-1:0] lvl1_o,
    input logic [LVL_W-1:0] lvl2_o,
    input logic [LVL_W+1:0] angle_q,
    input step_mode_e       mode_q
);

    localparam int unsigned ANG_W = LVL_W + 2;
    localparam logic [LVL_W-1:0] HALF_CODE = LVL_W'(2 ** LVL_W / 2 - 1);

    step_mode_e       mode_norm;
    logic [ANG_W-1:0] grid_c;
    logic [ANG_W-1:0] fwd_c;
    logic [ANG_W-1:0] bwd_c;

    always_comb begin
        mode_norm = (mode_i == MODE_RSVD) ? MODE_MICRO : step_mode_e'(mode_i);
        grid_c    = ANG_W'(1) << grid_log2(mode_q, ANG_W);
        fwd_c     = angle_q + grid_c;
        bwd_c     = angle_q - grid_c;
    end

    // R7
    ph1_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph1_o) |-> (lvl1_o == '1 || $past(lvl1_o) == '1));

    // R7
    ph2_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph2_o) |-> (lvl2_o == '1 || $past(lvl2_o) == '1));

    // R8
    step_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !rev_i && mode_norm == mode_q) |=> angle_q == $past(fwd_c));

    // R8
    step_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && rev_i && mode_norm == mode_q) |=> angle_q == $past(bwd_c));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && mode_norm == mode_q) |=>
            ($stable(angle_q) && $stable(lvl1_o) && $stable(lvl2_o) && $stable(ph1_o) && $stable(ph2_o)));

    // R3
    full_one_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FULL) |->
            (((lvl1_o == '1) != (lvl2_o == '1)) && (lvl1_o == '1 || lvl1_o == '0)
             && (lvl2_o == '1 || lvl2_o == '0)));

    // R4
    half_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HALF) |->
            ((lvl1_o == '0 || lvl1_o == HALF_CODE || lvl1_o == '1)
             && (lvl2_o == '0 || lvl2_o == HALF_CODE || lvl2_o == '1)));

endmodule

bind microstep_seq microstep_seq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .rev_i   (rev_i),
    .mode_i  (mode_i),
    .ph1_o   (ph1_o),
    .ph2_o   (ph2_o),
    .lvl1_o  (lvl1_o),
    .lvl2_o  (lvl2_o),
    .angle_q (angle_q),
    .mode_q  (mode_q)
);

// File: tb/tb_microstep_seq.sv
module tb_microstep_seq;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       step_i = 1'b0;
    logic       rev_i  = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       ph1_o, ph2_o;
    logic [3:0] lvl1_o, lvl2_o;
    logic [5:0] pos_o;

    int checks = 0;
    int fails  = 0;
    int ref_angle = 0;
    int ref_mode  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    microstep_seq #(.LVL_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .rev_i(rev_i), .mode_i(mode_i),
        .ph1_o(ph1_o), .ph2_o(ph2_o), .lvl1_o(lvl1_o), .lvl2_o(lvl2_o), .pos_o(pos_o)
    );

    function automatic int grid_of(int m);
        return (m == 0) ? 16 : (m == 1) ? 8 : 1;
    endfunction

    function automatic int axis_dist(int w);
        int d0, d32, d64, d;
        d0  = w;
        d32 = (w >= 32) ? w - 32 : 32 - w;
        d64 = 64 - w;
        d   = d0;
        if (d32 < d) d = d32;
        if (d64 < d) d = d64;
        return d;
    endfunction

    function automatic int exp_lvl(int w, int m);
        int q;
        q = axis_dist(w);
        if (q == 16) return 15;
        if (m == 2) return q;
        if (m == 1) return (q == 0) ? 0 : 7;
        return 0;
    endfunction

    function automatic int exp_ph(int w);
        return ((w < 64 - w ? w : 64 - w) < 16) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic check_outputs(string req);
        int w2;
        w2 = (ref_angle + 48) % 64;
        chk(req, "pos", int'(pos_o), ref_angle / grid_of(ref_mode));
        chk(req, "ph1", int'(ph1_o), exp_ph(ref_angle));
        chk(req, "lvl1", int'(lvl1_o), exp_lvl(ref_angle, ref_mode));
        chk("R6", "ph2", int'(ph2_o), exp_ph(w2));
        chk("R6", "lvl2", int'(lvl2_o), exp_lvl(w2, ref_mode));
    endtask

    task automatic apply_step(bit rev);
        @(negedge clk);
        step_i = 1'b1;
        rev_i  = rev;
        @(negedge clk);
        step_i = 1'b0;
        ref_angle = (ref_angle + (rev ? -grid_of(ref_mode) : grid_of(ref_mode)) + 64) % 64;
    endtask

    task automatic set_mode(int m, bit with_step);
        int g;
        @(negedge clk);
        mode_i = 2'(m);
        step_i = with_step;
        rev_i  = 1'b0;
        @(negedge clk);
        step_i = 1'b0;
        ref_mode  = (m == 3) ? 2 : m;
        g         = grid_of(ref_mode);
        ref_angle = (((ref_angle + g / 2) / g) * g) % 64;
        if (with_step) ref_angle = (ref_angle + g) % 64;
    endtask

    task automatic goto_micro(int target);
        if (ref_mode != 2) set_mode(2, 1'b0);
        while (ref_angle != target) apply_step(1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "pos in reset", int'(pos_o), 0);
        chk("R1", "lvl2 in reset", int'(lvl2_o), 15);
        rst_n = 1'b1;
        @(negedge clk);
        ref_angle = 0;
        ref_mode  = 0;
        chk("R1", "ph1", int'(ph1_o), 1);
        chk("R1", "ph2", int'(ph2_o), 0);
        chk("R2", "lvl1 full current code", int'(lvl1_o), 4'b0000);
        chk("R2", "lvl2 no current code", int'(lvl2_o), 4'b1111);
        check_outputs("R1");
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) begin
            apply_step(1'b0);
            check_outputs("R3");
        end
        chk("R8", "full wrap pos", int'(pos_o), 0);
        apply_step(1'b1);
        chk("R8", "full reverse wrap pos", int'(pos_o), 3);
        apply_step(1'b1);
        check_outputs("R8");
    endtask

    task automatic t_half();
        set_mode(1, 1'b0);
        check_outputs("R4");
        for (int i = 0; i < 8; i++) begin
            apply_step(1'b1);
            check_outputs("R4");
        end
        goto_micro(0);
        set_mode(1, 1'b0);
        apply_step(1'b0);
        chk("R4", "half pos1 lvl1 71.4pct", int'(lvl1_o), 7);
    endtask

    task automatic t_micro();
        logic       ph_prev;
        logic [3:0] lvl_prev;
        set_mode(2, 1'b0);
        goto_micro(0);
        for (int i = 0; i < 64; i++) begin
            ph_prev  = ph1_o;
            lvl_prev = lvl1_o;
            apply_step(1'b0);
            check_outputs("R5");
            if (ph1_o != ph_prev)
                chk("R7", "ph1 flip at zero", int'(lvl1_o == 4'hF || lvl_prev == 4'hF), 1);
        end
        chk("R8", "micro wrap pos", int'(pos_o), 0);
        apply_step(1'b1);
        chk("R8", "micro reverse wrap pos", int'(pos_o), 63);
        chk("R7", "ph1 at angle 63", int'(ph1_o), 1);
    endtask

    task automatic t_idle();
        goto_micro(21);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rev_i = ~rev_i;
        end
        @(negedge clk);
        check_outputs("R9");
    endtask

    task automatic t_remap();
        goto_micro(8);
        set_mode(0, 1'b0);
        chk("R10", "tie rounds up pos", int'(pos_o), 1);
        goto_micro(7);
        set_mode(0, 1'b0);
        chk("R10", "round down pos", int'(pos_o), 0);
        goto_micro(60);
        set_mode(0, 1'b0);
        chk("R10", "wrap to 0 pos", int'(pos_o), 0);
        check_outputs("R10");
        goto_micro(44);
        set_mode(1, 1'b0);
        chk("R10", "half remap pos", int'(pos_o), 6);
        goto_micro(20);
        set_mode(0, 1'b1);
        chk("R10", "remap then step pos", int'(pos_o), 2);
        check_outputs("R10");
        set_mode(3, 1'b0);
        apply_step(1'b0);
        chk("R10", "mode 11 micro pos", int'(pos_o), 33);
        check_outputs("R10");
    endtask

    initial begin
        t_reset();
        t_full();
        t_half();
        t_micro();
        t_idle();
        t_remap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule